// File: doc/BRIEF.md
# Halt-Mode Power Sequencer

This block decides what happens to the clocks of a small 8-bit controller when the CPU executes its halt instruction. Two configuration inputs choose the outcome. The oscillator-interrupt enable picks between a full halt, which stops everything including the main oscillator, and an active halt, which keeps the main oscillator and its wake-up timebase running while the peripheral and CPU clocks are gated. A watchdog-compatibility option decides whether a full-halt request made while the watchdog runs is honoured or turned into an immediate watchdog reset.

While halted, the block watches its wake-up sources. These are a reset request, any interrupt line whose exit-capability flag is set, and, in active halt only, the periodic oscillator interrupt. When one of them arrives, the oscillator comes back on at once and the CPU and peripheral clocks stay gated for a settling window of `SETTLE_CYCLES` clocks (4096 by default). After the window, a single dispatch cycle tells the CPU either to fetch the reset vector or to service the interrupt. The interrupt path also pushes the condition codes and clears the interrupt mask.

Top module: `hps_power_seq`

## Requirements
- R1: With `osc_irq_en`=0, and without the watchdog-reset condition of R3, a rising edge of `halt_req` drives `osc_on`, `periph_clk_en` and `cpu_clk_en` to 0 one clock later.
- R2: With `osc_irq_en`=1, a rising edge of `halt_req` gives `osc_on`=1, `periph_clk_en`=0 and `cpu_clk_en`=0 one clock later. `wdg_reset` is never raised, whatever `wdg_en` and `wdg_halt_opt` are.
- R3: With `osc_irq_en`=0, `wdg_en`=1 and `wdg_halt_opt`=0, a rising edge of `halt_req` does not halt. `wdg_reset` is 1 for exactly one clock, starting one clock later, and all three clock enables stay 1.
- R4: Only a 0-to-1 transition of `halt_req` seen in the run state is acted on. A level held high after the block returns to run does not start a new halt.
- R5: While halted, interrupt line i (bit i of `irq_pend`) wakes the block only if bit i of `irq_exit_cap` is 1. Pending lines without that flag leave every clock enable unchanged.
- R6: `osc_tick_irq` wakes the block from active halt. It is ignored in full halt.
- R7: A wake-up sampled at clock edge E sets `osc_on`=1 after E. `cpu_clk_en` and `periph_clk_en` stay 0 after edges E through E+SETTLE_CYCLES-1 and become 1 after edge E+SETTLE_CYCLES.
- R8: A wake-up caused by `wake_rst` ends with `fetch_rst_vec`=1 for the single cycle in which `cpu_clk_en` first returns to 1. `serve_irq` stays 0.
- R9: A wake-up caused by an interrupt ends with `serve_irq`, `push_cc` and `clr_imask` all 1 for that single cycle. `fetch_rst_vec` stays 0.
- R10: When `wake_rst` and a qualified interrupt arrive in the same cycle, the reset path is taken.
- R11: `wake_rst` asserted during the settling window restarts the full SETTLE_CYCLES count from that edge and forces the reset dispatch of R8.
- R12: After `rst_n` is released, the block is in run: all three clock enables are 1 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | Halt instruction strobe, acted on at its rising edge |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_opt | input | 1 | 1: halt allowed with watchdog running; 0: halt becomes watchdog reset |
| osc_irq_en | input | 1 | Oscillator interrupt enabled, selects active halt |
| wake_rst | input | 1 | Reset wake-up request, level |
| irq_pend | input | NUM_IRQ | Pending interrupt lines, level |
| irq_exit_cap | input | NUM_IRQ | Per-line flag: line may end a halt |
| osc_tick_irq | input | 1 | Periodic oscillator interrupt |
| osc_on | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdg_reset | output | 1 | One-cycle watchdog reset request |
| fetch_rst_vec | output | 1 | One-cycle order to fetch the reset vector |
| serve_irq | output | 1 | One-cycle order to service the interrupt |
| push_cc | output | 1 | One-cycle condition-code push strobe |
| clr_imask | output | 1 | One-cycle interrupt-mask clear strobe |

## Verification
The halt decision and the watchdog reset pulse appear one clock after the edge that captures the rising `halt_req`. The bench therefore drives on falling edges and reads the next falling edge. A wake-up sampled at edge E keeps the CPU gated through E+SETTLE_CYCLES-1. The bench counts exactly that many falling-edge samples with `cpu_clk_en` low, then expects the dispatch pulse on the following sample and the run state on the one after. A restart by reset mid-window moves E to the edge that sampled `wake_rst`. The bench uses a settling window of 16 so that it can sweep all eight configuration combinations and every interrupt line.

// File: rtl/hps_pkg.sv
package hps_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_HALT     = 3'd1,
      ST_AHALT    = 3'd2,
      ST_SETTLE   = 3'd3,
      ST_DISPATCH = 3'd4
   } hps_state_e;

   typedef enum logic [1:0] {
      DEC_NONE   = 2'd0,
      DEC_FULL   = 2'd1,
      DEC_ACTIVE = 2'd2,
      DEC_WDGRST = 2'd3
   } hps_dec_e;

   typedef enum logic {
      SRC_RESET = 1'b0,
      SRC_IRQ   = 1'b1
   } hps_src_e;

endpackage

// File: rtl/hps_halt_decide.sv
module hps_halt_decide
   import hps_pkg::*;
(
   input  logic     halt_go,
   input  logic     osc_irq_en,
   input  logic     wdg_en,
   input  logic     wdg_halt_opt,
   output hps_dec_e decision
);

   always_comb begin
      if (!halt_go)
         decision = DEC_NONE;
      else if (osc_irq_en)
         decision = DEC_ACTIVE;          // timebase keeps running, no watchdog reset
      else if (wdg_en && !wdg_halt_opt)
         decision = DEC_WDGRST;          // halt not compatible with running watchdog
      else
         decision = DEC_FULL;
   end

endmodule

// File: rtl/hps_wake_qual.sv
module hps_wake_qual #(
   parameter int unsigned NUM_IRQ = 4
) (
   input  logic               wake_rst,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_exit_cap,
   input  logic               osc_tick_irq,
   input  logic               tick_allowed,
   output logic               wake_any,
   output logic               wake_is_rst
);

   logic [NUM_IRQ-1:0] line_ok;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign line_ok[i] = irq_pend[i] & irq_exit_cap[i];
   end

   logic irq_wake;
   assign irq_wake    = (|line_ok) | (osc_tick_irq & tick_allowed);
   assign wake_is_rst = wake_rst;
   assign wake_any    = wake_rst | irq_wake;

endmodule

// File: rtl/hps_settle_ctr.sv
module hps_settle_ctr #(
   parameter int unsigned SETTLE_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic done
);

   localparam int unsigned CW   = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);
   localparam bit POW2 = ((1 << CW) == SETTLE_CYCLES);

   if (SETTLE_CYCLES < 2) begin : g_bad_len
      $error("SETTLE_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && !done)
         cnt_q <= cnt_q + 1'b1;
   end

   if (POW2) begin : g_pow2
      assign done = &cnt_q;
   end else begin : g_cmp
      assign done = (cnt_q == LAST);
   end

   // R7: the count never exceeds the last slot of the window
   p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R7: a clear always restarts at zero
   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));

endmodule

// File: rtl/hps_power_seq.sv
module hps_power_seq
   import hps_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 4096,
   parameter int unsigned NUM_IRQ       = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_req,
   input  logic               wdg_en,
   input  logic               wdg_halt_opt,
   input  logic               osc_irq_en,
   input  logic               wake_rst,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_exit_cap,
   input  logic               osc_tick_irq,
   output logic               osc_on,
   output logic               periph_clk_en,
   output logic               cpu_clk_en,
   output logic               wdg_reset,
   output logic               fetch_rst_vec,
   output logic               serve_irq,
   output logic               push_cc,
   output logic               clr_imask
);

   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end

   hps_state_e state_q;
   hps_src_e   src_q;
   logic       halt_q;
   logic       wdg_rst_q;

   // rising-edge detect on the halt strobe
   logic halt_go;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_q <= 1'b0;
      else        halt_q <= halt_req;
   end
   assign halt_go = halt_req & ~halt_q & (state_q == ST_RUN);

   hps_dec_e decision;
   hps_halt_decide u_decide (
      .halt_go      (halt_go),
      .osc_irq_en   (osc_irq_en),
      .wdg_en       (wdg_en),
      .wdg_halt_opt (wdg_halt_opt),
      .decision     (decision)
   );

   logic wake_any, wake_is_rst;
   hps_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_wake (
      .wake_rst     (wake_rst),
      .irq_pend     (irq_pend),
      .irq_exit_cap (irq_exit_cap),
      .osc_tick_irq (osc_tick_irq),
      .tick_allowed (state_q == ST_AHALT),
      .wake_any     (wake_any),
      .wake_is_rst  (wake_is_rst)
   );

   logic halted;
   logic ctr_clear, settle_done;
   assign halted    = (state_q == ST_HALT) || (state_q == ST_AHALT);
   assign ctr_clear = (halted && wake_any) || ((state_q == ST_SETTLE) && wake_rst);

   hps_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ctr_clear),
      .run   (state_q == ST_SETTLE),
      .done  (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         src_q     <= SRC_RESET;
         wdg_rst_q <= 1'b0;
      end else begin
         wdg_rst_q <= (decision == DEC_WDGRST);
         unique case (state_q)
            ST_RUN: begin
               if (decision == DEC_FULL)        state_q <= ST_HALT;
               else if (decision == DEC_ACTIVE) state_q <= ST_AHALT;
            end
            ST_HALT, ST_AHALT: begin
               if (wake_any) begin
                  state_q <= ST_SETTLE;
                  src_q   <= wake_is_rst ? SRC_RESET : SRC_IRQ;
               end
            end
            ST_SETTLE: begin
               if (wake_rst)         src_q   <= SRC_RESET;
               else if (settle_done) state_q <= ST_DISPATCH;
            end
            ST_DISPATCH: state_q <= ST_RUN;
            default:     state_q <= ST_RUN;
         endcase
      end
   end

   logic live;
   assign live          = (state_q == ST_RUN) || (state_q == ST_DISPATCH);
   assign osc_on        = (state_q != ST_HALT);
   assign periph_clk_en = live;
   assign cpu_clk_en    = live;
   assign wdg_reset     = wdg_rst_q;
   assign fetch_rst_vec = (state_q == ST_DISPATCH) && (src_q == SRC_RESET);
   assign serve_irq     = (state_q == ST_DISPATCH) && (src_q == SRC_IRQ);
   assign push_cc       = serve_irq;
   assign clr_imask     = serve_irq;

   p_full_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (decision == DEC_FULL) |=> (!osc_on && !periph_clk_en && !cpu_clk_en));

   p_active_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (decision == DEC_ACTIVE) |=> (osc_on && !cpu_clk_en && !wdg_reset));

   p_wdg_no_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (decision == DEC_WDGRST) |=> (wdg_reset && cpu_clk_en && osc_on));

   p_wdg_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_reset |=> !wdg_reset);

   p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && halt_q) |=> (state_q != ST_HALT || $past(state_q) != ST_RUN));

   p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && !wake_rst && ((irq_pend & irq_exit_cap) == '0))
      |=> (state_q == ST_HALT));

   p_tick_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AHALT && osc_tick_irq) |=> (state_q == ST_SETTLE && osc_on));

   p_gated_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> $past(settle_done));

   p_rst_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && wake_rst) |=> (state_q == ST_SETTLE && src_q == SRC_RESET));

   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE && wake_rst) |=> (state_q == ST_SETTLE && !cpu_clk_en));

   p_one_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_rst_vec || serve_irq) |=> !(fetch_rst_vec || serve_irq));

endmodule

// File: tb/tb_hps_power_seq.sv
module tb_hps_power_seq;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int NIRQ = 4;
   localparam int WD_CYCLES = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 0, wdg_en = 0, wdg_halt_opt = 0, osc_irq_en = 0;
   logic wake_rst = 0, osc_tick_irq = 0;
   logic [NIRQ-1:0] irq_pend = '0, irq_exit_cap = '0;
   logic osc_on, periph_clk_en, cpu_clk_en, wdg_reset;
   logic fetch_rst_vec, serve_irq, push_cc, clr_imask;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hps_power_seq #(.SETTLE_CYCLES(N), .NUM_IRQ(NIRQ)) dut (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdg_en(wdg_en),
      .wdg_halt_opt(wdg_halt_opt), .osc_irq_en(osc_irq_en), .wake_rst(wake_rst),
      .irq_pend(irq_pend), .irq_exit_cap(irq_exit_cap), .osc_tick_irq(osc_tick_irq),
      .osc_on(osc_on), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
      .wdg_reset(wdg_reset), .fetch_rst_vec(fetch_rst_vec), .serve_irq(serve_irq),
      .push_cc(push_cc), .clr_imask(clr_imask)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // packs {osc, periph, cpu, wdg_reset, fetch, serve, push, clr}
   function automatic logic [31:0] outs();
      return {24'd0, osc_on, periph_clk_en, cpu_clk_en, wdg_reset,
              fetch_rst_vec, serve_irq, push_cc, clr_imask};
   endfunction

   localparam logic [31:0] O_RUN   = 32'b1110_0000;
   localparam logic [31:0] O_FULL  = 32'b0000_0000;
   localparam logic [31:0] O_AHALT = 32'b1000_0000;
   localparam logic [31:0] O_WDG   = 32'b1111_0000;
   localparam logic [31:0] O_FETCH = 32'b1110_1000;
   localparam logic [31:0] O_SERVE = 32'b1110_0111;

   task automatic pulse_halt();
      @(negedge clk) halt_req = 1'b1;
      @(negedge clk) halt_req = 1'b0;
   endtask

   // called at the negedge where the wake source was just driven
   task automatic settle(input bit rst_path, input string req);
      int bad = 0;
      @(negedge clk);
      wake_rst = 0; irq_pend = '0; irq_exit_cap = '0; osc_tick_irq = 0;
      chk({req, " R7 osc back on, cpu gated"}, {osc_on, cpu_clk_en, periph_clk_en}, 3'b100);
      for (int k = 1; k < N; k++) begin
         @(negedge clk);
         if (cpu_clk_en !== 1'b0 || periph_clk_en !== 1'b0) bad++;
      end
      chk({req, " R7 gated whole window"}, bad, 0);
      @(negedge clk);
      chk(rst_path ? {req, " R8 reset dispatch"} : {req, " R9 irq dispatch"},
          outs(), rst_path ? O_FETCH : O_SERVE);
      @(negedge clk);
      chk({req, " R8 R9 single-cycle dispatch"}, outs(), O_RUN);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset state", outs(), O_RUN);

      // R1 R2 R3: sweep all configuration combinations
      for (int c = 0; c < 8; c++) begin
         osc_irq_en = c[2]; wdg_en = c[1]; wdg_halt_opt = c[0];
         pulse_halt();
         if (c[2]) begin
            chk("R2 active halt entry", outs(), O_AHALT);
         end else if (c[1] && !c[0]) begin
            chk("R3 watchdog reset instead of halt", outs(), O_WDG);
            @(negedge clk);
            chk("R3 watchdog reset one cycle", outs(), O_RUN);
         end else begin
            chk("R1 full halt entry", outs(), O_FULL);
         end
         if (!(c[1] && !c[0] && !c[2])) begin
            wake_rst = 1'b1;
            settle(1'b1, "sweep");
         end
      end

      // R5: each line blocked without its exit flag, accepted with it
      osc_irq_en = 0; wdg_en = 0; wdg_halt_opt = 0;
      for (int i = 0; i < NIRQ; i++) begin
         pulse_halt();
         irq_pend = NIRQ'(1 << i);
         irq_exit_cap = ~NIRQ'(1 << i);
         repeat (3) @(negedge clk);
         chk("R5 unflagged interrupt ignored", outs(), O_FULL);
         irq_exit_cap = NIRQ'(1 << i);
         settle(1'b0, "R5 flagged line");
      end

      // R6: tick ignored in full halt, accepted in active halt
      pulse_halt();
      osc_tick_irq = 1;
      repeat (3) @(negedge clk);
      chk("R6 tick ignored in full halt", outs(), O_FULL);
      osc_tick_irq = 0;
      wake_rst = 1;
      settle(1'b1, "R6 exit");
      osc_irq_en = 1;
      pulse_halt();
      osc_tick_irq = 1;
      settle(1'b0, "R6 tick wake");
      osc_irq_en = 0;

      // R10: simultaneous reset and interrupt
      pulse_halt();
      wake_rst = 1; irq_pend = 4'b0001; irq_exit_cap = 4'b0001;
      settle(1'b1, "R10 priority");

      // R11: reset in the middle of the window
      begin
         int bad = 0;
         pulse_halt();
         irq_pend = 4'b0010; irq_exit_cap = 4'b0010;
         @(negedge clk);
         irq_pend = '0; irq_exit_cap = '0;
         repeat (5) @(negedge clk);
         wake_rst = 1;
         @(negedge clk);            // restart edge sampled
         wake_rst = 0;
         if (cpu_clk_en !== 1'b0) bad++;
         for (int k = 1; k < N; k++) begin
            @(negedge clk);
            if (cpu_clk_en !== 1'b0) bad++;
         end
         chk("R11 restarted window fully gated", bad, 0);
         @(negedge clk);
         chk("R11 forced reset dispatch", outs(), O_FETCH);
         @(negedge clk);
      end

      // R4: held strobe does not retrigger
      begin
         int bad = 0;
         @(negedge clk) halt_req = 1'b1;
         @(negedge clk);
         chk("R4 entry on rising edge", outs(), O_FULL);
         wake_rst = 1;
         settle(1'b1, "R4 exit");
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (outs() !== O_RUN) bad++;
         end
         chk("R4 held level ignored", bad, 0);
         halt_req = 1'b0;
      end

      summary();
      $finish;
   end

endmodule